// File: doc/BRIEF.md
# Correlator Packet Header Builder

This block emits the fixed-size header that precedes every output data packet of a correlator. On a start request it freezes a snapshot of its metadata inputs and of its own counters. It then sends that snapshot one byte per accepted transfer over a valid/ready byte stream, and pulses a completion flag once the final byte has been taken. The header carries:

- the header length;
- the accumulation length;
- a packet index within the current accumulation;
- a running count of accumulations;
- an accumulation index within the current second;
- a set of delay words;
- the FFT shift and ADC overflow telemetry;
- a type byte;
- three identity bytes whose meaning depends on the type.

The block keeps three counters itself. A pulse on `new_acc` marks the start of a new accumulation. It advances the running accumulation count, clears the packet index and steps the per-second index. The per-second index returns to zero after `ACC_PER_SEC-1` and on every `pps` pulse, which keeps it aligned with a once-per-second timing mark. The packet index rises by one per completed header. The header length is `24 + 4*NUM_DELAYS` bytes, which is 40 with the default of four delays.

Top module: `corr_hdr_builder`

## Requirements
- R1: A header is exactly `24 + 4*NUM_DELAYS` bytes long (40 by default), and its first byte (index 0) holds that length.
- R2: Multi-byte words go out most significant byte first, at fixed positions in the default layout:
  - bytes 1-2: accumulation length;
  - bytes 12-27: delay words, delay 0 first (bits 31:0 of `delays`);
  - bytes 28-31: FFT shift;
  - bytes 32-35: ADC overflow count.
- R3: Byte 36 is the type code, 0 for power data and 1 for cross-correlation data (`kind`). For power data, bytes 37, 38 and 39 are the antenna number, the polarization code (0=X, 1=Y, 2=R, 3=L) and zero.
- R4: For cross-correlation data, bytes 37, 38 and 39 are the first antenna of the visibility, the second antenna, and the engine number.
- R5: The header content is the state of the inputs and counters in the cycle its start is accepted. Input changes and `new_acc` pulses during transmission do not alter it.
- R6: Byte 3 is the packet index. It is 0 after reset and after any `new_acc`, rises by one per completed header, and wraps from 255 to 0.
- R7: Bytes 4-7 hold the accumulation count. It is 0 after reset and rises by one per `new_acc` pulse.
- R8: Bytes 8-11 hold the per-second index. It rises by one per `new_acc`, wraps from `ACC_PER_SEC-1` to 0, and is forced to 0 by `pps`, including when `pps` and `new_acc` coincide.
- R9: A byte is consumed only in a cycle with `hdr_valid` and `hdr_ready` both high. While `hdr_valid` is high and `hdr_ready` is low, `hdr_valid` stays high and `hdr_data` stays unchanged.
- R10: `hdr_done` is high for exactly one cycle, the cycle after the last byte is accepted, and `hdr_valid` is low in that cycle.
- R11: A `start` raised while a header is in progress is ignored, so no second header follows.
- R12: After reset `hdr_valid` and `hdr_done` are low and all three counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_acc | input | 1 | Pulse marking the start of a new accumulation |
| pps | input | 1 | Once-per-second alignment pulse |
| start | input | 1 | Request to build and send one header (taken when idle) |
| kind | input | 1 | Packet type: 0 power, 1 cross-correlation |
| acc_len | input | 16 | Accumulation length |
| delays | input | 32*NUM_DELAYS | Delay words, delay 0 in bits 31:0 |
| fft_shift | input | 32 | FFT shift setting |
| adc_ovf | input | 32 | ADC overflow count |
| ant_id | input | 8 | Antenna number for power packets |
| pol_code | input | 2 | Polarization code for power packets |
| vis_ant0 | input | 8 | First antenna of the visibility |
| vis_ant1 | input | 8 | Second antenna of the visibility |
| engine_id | input | 8 | Engine or board number |
| hdr_ready | input | 1 | Downstream accepts a byte |
| hdr_valid | output | 1 | `hdr_data` holds a header byte |
| hdr_data | output | 8 | Header byte |
| hdr_done | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench builds the block with `ACC_PER_SEC = 4` and the default four delay words. This keeps the 40-byte layout while letting a handful of `new_acc` pulses carry the per-second index through its wrap, and through its collision with `pps`. A run of 257 headers inside one accumulation drives the 8-bit packet index through its wrap. Ready patterns with long stalls, and metadata rewritten in the middle of a header, show that the frozen snapshot and the held byte survive back-pressure.

// File: rtl/corr_hdr_pkg.sv
package corr_hdr_pkg;

    typedef enum logic {
        KIND_POWER = 1'b0,
        KIND_CROSS = 1'b1
    } hdr_kind_e;

    typedef enum logic [1:0] {
        POL_X = 2'd0,
        POL_Y = 2'd1,
        POL_R = 2'd2,
        POL_L = 2'd3
    } pol_e;

    // Frozen per-header metadata (delay words are held separately)
    typedef struct packed {
        logic [15:0] acc_len;
        logic [7:0]  pkt;
        logic [31:0] glob;
        logic [31:0] sec;
        logic [31:0] fft;
        logic [31:0] ovf;
        logic [7:0]  type_b;
        logic [7:0]  id0;
        logic [7:0]  id1;
        logic [7:0]  id2;
    } hdr_meta_t;

    // Byte of a 32-bit word, big-endian: sub 0 is the top byte
    function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] sub);
        logic [7:0] r;
        case (sub)
            2'd0:    r = w[31:24];
            2'd1:    r = w[23:16];
            2'd2:    r = w[15:8];
            default: r = w[7:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/corr_hdr_counters.sv
module corr_hdr_counters #(
    parameter int ACC_PER_SEC = 50,
    parameter int SEC_W       = $clog2(ACC_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_acc,
    input  logic             pps,
    input  logic             hdr_end,
    output logic [7:0]       pkt_num,
    output logic [31:0]      glob_cnt,
    output logic [SEC_W-1:0] sec_idx
);

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(ACC_PER_SEC - 1);

    typedef struct packed {
        logic [7:0]       pkt;
        logic [31:0]      glob;
        logic [SEC_W-1:0] sec;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hdr_end) begin
            cnt_d.pkt = cnt_q.pkt + 8'd1;
        end
        if (new_acc) begin
            cnt_d.glob = cnt_q.glob + 32'd1;
            cnt_d.pkt  = 8'd0;
            cnt_d.sec  = (cnt_q.sec == SEC_LAST) ? '0 : cnt_q.sec + 1'b1;
        end
        if (pps) begin
            cnt_d.sec = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pkt_num  = cnt_q.pkt;
    assign glob_cnt = cnt_q.glob;
    assign sec_idx  = cnt_q.sec;

endmodule

// File: rtl/corr_hdr_snapshot.sv
module corr_hdr_snapshot
    import corr_hdr_pkg::*;
#(
    parameter int NUM_DELAYS = 4,
    parameter int SEC_W      = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture,
    input  logic                          kind,
    input  logic [15:0]                   acc_len,
    input  logic [7:0]                    pkt_num,
    input  logic [31:0]                   glob_cnt,
    input  logic [SEC_W-1:0]              sec_idx,
    input  logic [NUM_DELAYS*32-1:0]      delays,
    input  logic [31:0]                   fft_shift,
    input  logic [31:0]                   adc_ovf,
    input  logic [7:0]                    ant_id,
    input  logic [1:0]                    pol_code,
    input  logic [7:0]                    vis_ant0,
    input  logic [7:0]                    vis_ant1,
    input  logic [7:0]                    engine_id,
    output hdr_meta_t                     meta,
    output logic [NUM_DELAYS-1:0][31:0]   dly
);

    hdr_meta_t                   meta_d, meta_q;
    logic [NUM_DELAYS-1:0][31:0] dly_d, dly_q;

    always_comb begin
        meta_d = meta_q;
        if (capture) begin
            meta_d.acc_len = acc_len;
            meta_d.pkt     = pkt_num;
            meta_d.glob    = glob_cnt;
            meta_d.sec     = 32'(sec_idx);
            meta_d.fft     = fft_shift;
            meta_d.ovf     = adc_ovf;
            if (hdr_kind_e'(kind) == KIND_CROSS) begin
                meta_d.type_b = 8'd1;
                meta_d.id0    = vis_ant0;
                meta_d.id1    = vis_ant1;
                meta_d.id2    = engine_id;
            end else begin
                meta_d.type_b = 8'd0;
                meta_d.id0    = ant_id;
                meta_d.id1    = {6'd0, pol_code};
                meta_d.id2    = 8'd0;
            end
        end
    end

    for (genvar g = 0; g < NUM_DELAYS; g++) begin : g_dly
        assign dly_d[g] = capture ? delays[g*32 +: 32] : dly_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            dly_q  <= '0;
        end else begin
            meta_q <= meta_d;
            dly_q  <= dly_d;
        end
    end

    assign meta = meta_q;
    assign dly  = dly_q;

endmodule

// File: rtl/corr_hdr_sequencer.sv
module corr_hdr_sequencer #(
    parameter int HDR_LEN = 40,
    parameter int IDX_W   = $clog2(HDR_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ready,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             capture,
    output logic             hdr_end
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        capture    = 1'b0;
        hdr_end    = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                capture    = 1'b1;
                seq_d.busy = 1'b1;
                seq_d.idx  = '0;
            end
        end else if (ready) begin
            if (seq_q.idx == IDX_LAST) begin
                hdr_end    = 1'b1;
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.idx  = '0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = seq_q.busy;
    assign idx  = seq_q.idx;
    assign done = seq_q.done;

endmodule

// File: rtl/corr_hdr_bytesel.sv
module corr_hdr_bytesel
    import corr_hdr_pkg::*;
#(
    parameter int NUM_DELAYS = 4,
    parameter int HDR_LEN    = 24 + 4 * NUM_DELAYS,
    parameter int IDX_W      = $clog2(HDR_LEN)
) (
    input  hdr_meta_t                   meta,
    input  logic [NUM_DELAYS-1:0][31:0] dly,
    input  logic [IDX_W-1:0]            idx,
    output logic [7:0]                  byte_out
);

    localparam int P_ACC  = 1;
    localparam int P_PKT  = 3;
    localparam int P_GLOB = 4;
    localparam int P_SEC  = 8;
    localparam int P_DLY  = 12;
    localparam int P_FFT  = P_DLY + 4 * NUM_DELAYS;
    localparam int P_OVF  = P_FFT + 4;
    localparam int P_TYPE = P_OVF + 4;
    localparam int P_ID   = P_TYPE + 1;

    localparam logic [IDX_W-1:0] I_ACC  = IDX_W'(P_ACC);
    localparam logic [IDX_W-1:0] I_PKT  = IDX_W'(P_PKT);
    localparam logic [IDX_W-1:0] I_GLOB = IDX_W'(P_GLOB);
    localparam logic [IDX_W-1:0] I_SEC  = IDX_W'(P_SEC);
    localparam logic [IDX_W-1:0] I_DLY  = IDX_W'(P_DLY);
    localparam logic [IDX_W-1:0] I_FFT  = IDX_W'(P_FFT);
    localparam logic [IDX_W-1:0] I_OVF  = IDX_W'(P_OVF);
    localparam logic [IDX_W-1:0] I_TYPE = IDX_W'(P_TYPE);
    localparam logic [IDX_W-1:0] I_ID   = IDX_W'(P_ID);

    logic [IDX_W-1:0] rel;
    logic [1:0]       sub;

    always_comb begin
        byte_out = 8'd0;
        rel      = '0;
        sub      = idx[1:0];
        if (idx == '0) begin
            byte_out = 8'(HDR_LEN);
        end else if (idx == I_ACC) begin
            byte_out = meta.acc_len[15:8];
        end else if (idx == I_ACC + 1'b1) begin
            byte_out = meta.acc_len[7:0];
        end else if (idx == I_PKT) begin
            byte_out = meta.pkt;
        end else if (idx < I_SEC) begin
            rel      = idx - I_GLOB;
            byte_out = word_byte(meta.glob, rel[1:0]);
        end else if (idx < I_DLY) begin
            rel      = idx - I_SEC;
            byte_out = word_byte(meta.sec, rel[1:0]);
        end else if (idx < I_FFT) begin
            rel = idx - I_DLY;
            for (int k = 0; k < NUM_DELAYS; k++) begin
                if (rel[IDX_W-1:2] == (IDX_W-2)'(k)) begin
                    byte_out = word_byte(dly[k], rel[1:0]);
                end
            end
        end else if (idx < I_OVF) begin
            rel      = idx - I_FFT;
            byte_out = word_byte(meta.fft, rel[1:0]);
        end else if (idx < I_TYPE) begin
            rel      = idx - I_OVF;
            byte_out = word_byte(meta.ovf, rel[1:0]);
        end else if (idx == I_TYPE) begin
            byte_out = meta.type_b;
        end else if (idx == I_ID) begin
            byte_out = meta.id0;
        end else if (idx == I_ID + 1'b1) begin
            byte_out = meta.id1;
        end else begin
            byte_out = meta.id2;
        end
        sub = rel[1:0];
    end

endmodule

// File: rtl/corr_hdr_builder.sv
module corr_hdr_builder
    import corr_hdr_pkg::*;
#(
    parameter int NUM_DELAYS  = 4,
    parameter int ACC_PER_SEC = 50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     new_acc,
    input  logic                     pps,
    input  logic                     start,
    input  logic                     kind,
    input  logic [15:0]              acc_len,
    input  logic [NUM_DELAYS*32-1:0] delays,
    input  logic [31:0]              fft_shift,
    input  logic [31:0]              adc_ovf,
    input  logic [7:0]               ant_id,
    input  logic [1:0]               pol_code,
    input  logic [7:0]               vis_ant0,
    input  logic [7:0]               vis_ant1,
    input  logic [7:0]               engine_id,
    input  logic                     hdr_ready,
    output logic                     hdr_valid,
    output logic [7:0]               hdr_data,
    output logic                     hdr_done
);

    localparam int HDR_LEN = 24 + 4 * NUM_DELAYS;
    localparam int IDX_W   = $clog2(HDR_LEN);
    localparam int SEC_W   = $clog2(ACC_PER_SEC);

    logic [7:0]                  pkt_num;
    logic [31:0]                 glob_cnt;
    logic [SEC_W-1:0]            sec_idx;
    logic                        busy;
    logic [IDX_W-1:0]            idx;
    logic                        capture;
    logic                        hdr_end;
    hdr_meta_t                   meta;
    logic [NUM_DELAYS-1:0][31:0] dly;

    corr_hdr_counters #(
        .ACC_PER_SEC (ACC_PER_SEC),
        .SEC_W       (SEC_W)
    ) i_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_acc  (new_acc),
        .pps      (pps),
        .hdr_end  (hdr_end),
        .pkt_num  (pkt_num),
        .glob_cnt (glob_cnt),
        .sec_idx  (sec_idx)
    );

    corr_hdr_sequencer #(
        .HDR_LEN (HDR_LEN),
        .IDX_W   (IDX_W)
    ) i_sequencer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ready   (hdr_ready),
        .busy    (busy),
        .idx     (idx),
        .done    (hdr_done),
        .capture (capture),
        .hdr_end (hdr_end)
    );

    corr_hdr_snapshot #(
        .NUM_DELAYS (NUM_DELAYS),
        .SEC_W      (SEC_W)
    ) i_snapshot (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .kind      (kind),
        .acc_len   (acc_len),
        .pkt_num   (pkt_num),
        .glob_cnt  (glob_cnt),
        .sec_idx   (sec_idx),
        .delays    (delays),
        .fft_shift (fft_shift),
        .adc_ovf   (adc_ovf),
        .ant_id    (ant_id),
        .pol_code  (pol_code),
        .vis_ant0  (vis_ant0),
        .vis_ant1  (vis_ant1),
        .engine_id (engine_id),
        .meta      (meta),
        .dly       (dly)
    );

    corr_hdr_bytesel #(
        .NUM_DELAYS (NUM_DELAYS),
        .HDR_LEN    (HDR_LEN),
        .IDX_W      (IDX_W)
    ) i_bytesel (
        .meta     (meta),
        .dly      (dly),
        .idx      (idx),
        .byte_out (hdr_data)
    );

    assign hdr_valid = busy;

endmodule

// File: rtl/corr_hdr_builder_chk.sv
module corr_hdr_builder_chk #(
    parameter int ACC_PER_SEC = 50,
    parameter int SEC_W       = 6,
    parameter int HDR_LEN     = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             new_acc,
    input logic             pps,
    input logic             hdr_valid,
    input logic             hdr_ready,
    input logic [7:0]       hdr_data,
    input logic             hdr_done,
    input logic [7:0]       pkt_num,
    input logic [31:0]      glob_cnt,
    input logic [SEC_W-1:0] sec_idx
);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_data)));

    // R1
    first_byte_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_valid) |-> (hdr_data == 8'(HDR_LEN)));

    // R10
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> ($past(hdr_valid && hdr_ready) && !hdr_valid));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> !hdr_done);

    // R6
    pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_acc |=> (pkt_num == 8'd0));

    // R6
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !$past(new_acc)) |-> (pkt_num == 8'($past(pkt_num) + 8'd1)));

    // R7
    glob_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_acc |=> (glob_cnt == $past(glob_cnt) + 32'd1));

    // R8
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sec_idx) < ACC_PER_SEC);

    // R8
    pps_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pps |=> (sec_idx == '0));

endmodule

bind corr_hdr_builder corr_hdr_builder_chk #(
    .ACC_PER_SEC (ACC_PER_SEC),
    .SEC_W       (SEC_W),
    .HDR_LEN     (HDR_LEN)
) i_corr_hdr_builder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_acc   (new_acc),
    .pps       (pps),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .hdr_data  (hdr_data),
    .hdr_done  (hdr_done),
    .pkt_num   (pkt_num),
    .glob_cnt  (glob_cnt),
    .sec_idx   (sec_idx)
);

// File: tb/test_corr_hdr_builder.sv
module test_corr_hdr_builder;

    localparam int ND   = 4;
    localparam int APS  = 4;
    localparam int HLEN = 24 + 4 * ND;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            new_acc = 1'b0;
    logic            pps = 1'b0;
    logic            start = 1'b0;
    logic            kind = 1'b0;
    logic [15:0]     acc_len = '0;
    logic [ND*32-1:0] delays = '0;
    logic [31:0]     fft_shift = '0;
    logic [31:0]     adc_ovf = '0;
    logic [7:0]      ant_id = '0;
    logic [1:0]      pol_code = '0;
    logic [7:0]      vis_ant0 = '0;
    logic [7:0]      vis_ant1 = '0;
    logic [7:0]      engine_id = '0;
    logic            hdr_ready = 1'b0;
    logic            hdr_valid;
    logic [7:0]      hdr_data;
    logic            hdr_done;

    always #10 clk = ~clk;

    corr_hdr_builder #(.NUM_DELAYS(ND), .ACC_PER_SEC(APS)) i_corr_hdr_builder (
        .clk(clk), .rst_n(rst_n), .new_acc(new_acc), .pps(pps), .start(start),
        .kind(kind), .acc_len(acc_len), .delays(delays), .fft_shift(fft_shift),
        .adc_ovf(adc_ovf), .ant_id(ant_id), .pol_code(pol_code),
        .vis_ant0(vis_ant0), .vis_ant1(vis_ant1), .engine_id(engine_id),
        .hdr_ready(hdr_ready), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
        .hdr_done(hdr_done)
    );

    int checks = 0;
    int errors = 0;

    // model counters
    logic [7:0]  m_pkt  = '0;
    logic [31:0] m_glob = '0;
    logic [31:0] m_sec  = '0;
    logic [7:0]  expb [HLEN];

    typedef struct packed {
        logic        kind;
        logic [15:0] acc_len;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  c;
        logic [1:0]  pol;
        logic [31:0] fft;
        logic [31:0] ovf;
        logic [7:0]  rdy;
        logic [2:0]  n_acc;
        logic        pps_first;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 16'h0B72, 8'h03, 8'h07, 8'h02, 2'd0, 32'h0000_0FFF, 32'h0000_0000, 8'hFF,       3'd0, 1'b0},
        '{1'b1, 16'hFFFF, 8'h01, 8'h0D, 8'h05, 2'd3, 32'h1234_5678, 32'hDEAD_BEEF, 8'b1010_0110, 3'd1, 1'b0},
        '{1'b0, 16'h8001, 8'h0F, 8'h11, 8'h22, 2'd2, 32'hA5A5_0001, 32'h0000_0102, 8'b0000_0001, 3'd3, 1'b0},
        '{1'b1, 16'h0040, 8'h0A, 8'h0B, 8'h07, 2'd1, 32'h0F0F_F0F0, 32'hFFFF_FFFF, 8'b1100_1100, 3'd2, 1'b0},
        '{1'b0, 16'h0001, 8'h1C, 8'h00, 8'h00, 2'd1, 32'h8000_0000, 32'h0000_0031, 8'b0111_0111, 3'd0, 1'b1},
        '{1'b0, 16'h7FFE, 8'hFE, 8'h44, 8'h55, 2'd3, 32'h0000_0003, 32'h0102_0304, 8'hFF,       3'd1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int i, input bit mut);
        if (mut) return "R5";
        if (i == 0) return "R1";
        if (i == 3) return "R6";
        if (i >= 4 && i < 8) return "R7";
        if (i >= 8 && i < 12) return "R8";
        if (i < 36) return "R2";
        if (i == 36) return "R3";
        return (expb[36] == 8'd1) ? "R4" : "R3";
    endfunction

    function automatic void put32(input int p, input logic [31:0] w);
        expb[p]   = w[31:24];
        expb[p+1] = w[23:16];
        expb[p+2] = w[15:8];
        expb[p+3] = w[7:0];
    endfunction

    function automatic void build_exp();
        expb[0] = 8'(HLEN);
        expb[1] = acc_len[15:8];
        expb[2] = acc_len[7:0];
        expb[3] = m_pkt;
        put32(4, m_glob);
        put32(8, m_sec);
        for (int k = 0; k < ND; k++) put32(12 + 4 * k, delays[k*32 +: 32]);
        put32(28, fft_shift);
        put32(32, adc_ovf);
        expb[36] = kind ? 8'd1 : 8'd0;
        expb[37] = kind ? vis_ant0 : ant_id;
        expb[38] = kind ? vis_ant1 : {6'd0, pol_code};
        expb[39] = kind ? engine_id : 8'd0;
    endfunction

    function automatic void model_step(input bit na, input bit pp);
        if (na) begin
            m_glob = m_glob + 1;
            m_pkt  = 8'd0;
            m_sec  = (m_sec == APS - 1) ? 32'd0 : m_sec + 1;
        end
        if (pp) m_sec = 32'd0;
    endfunction

    task automatic pulse(input bit na, input bit pp);
        @(negedge clk);
        new_acc = na;
        pps     = pp;
        @(negedge clk);
        new_acc = 1'b0;
        pps     = 1'b0;
        model_step(na, pp);
    endtask

    task automatic set_meta(input vec_t v, input int vi);
        kind      = v.kind;
        acc_len   = v.acc_len;
        ant_id    = v.a;
        vis_ant0  = v.a;
        vis_ant1  = v.b;
        engine_id = v.c;
        pol_code  = v.pol;
        fft_shift = v.fft;
        adc_ovf   = v.ovf;
        for (int k = 0; k < ND; k++)
            delays[k*32 +: 32] = {8'(k + 1), 8'(vi), 16'hA55A ^ 16'(vi * 257)};
    endtask

    task automatic run_hdr(input logic [7:0] rdy, input bit mut);
        int n = 0;
        int cyc = 0;
        bit hold = 1'b0;
        logic [7:0] held = '0;
        build_exp();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < HLEN && cyc < 400) begin
            hdr_ready = rdy[cyc % 8];
            if (mut && cyc == 2) start = 1'b1;  // R11: ignored while busy
            if (mut && cyc == 3) begin
                start     = 1'b0;
                kind      = ~kind;
                fft_shift = ~fft_shift;
                adc_ovf   = ~adc_ovf;
                delays    = ~delays;
                acc_len   = ~acc_len;
                ant_id    = ~ant_id;
                vis_ant0  = ~vis_ant0;
                new_acc   = 1'b1;
            end
            if (mut && cyc == 4) begin
                new_acc = 1'b0;
                model_step(1'b1, 1'b0);
            end
            if (hold) chk(hdr_data == held, "R9", 32'(hdr_data), 32'(held));
            if (hdr_valid && hdr_ready) begin
                chk(hdr_data == expb[n], tag_of(n, mut), 32'(hdr_data), 32'(expb[n]));
                n++;
                hold = 1'b0;
            end else if (hdr_valid) begin
                hold = 1'b1;
                held = hdr_data;
            end else begin
                chk(1'b0, "R9", 32'(hdr_valid), 32'd1);
            end
            @(negedge clk);
            cyc++;
        end
        chk(n == HLEN, "R1", 32'(n), 32'(HLEN));
        chk(hdr_done == 1'b1, "R10", 32'(hdr_done), 32'd1);
        chk(hdr_valid == 1'b0, "R10", 32'(hdr_valid), 32'd0);
        hdr_ready = 1'b0;
        m_pkt = m_pkt + 8'd1;
        @(negedge clk);
        chk(hdr_done == 1'b0, "R10", 32'(hdr_done), 32'd0);
        chk(hdr_valid == 1'b0, "R11", 32'(hdr_valid), 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(hdr_valid == 1'b0, "R12", 32'(hdr_valid), 32'd0);
        chk(hdr_done == 1'b0, "R12", 32'(hdr_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hdr_valid == 1'b0, "R12", 32'(hdr_valid), 32'd0);

        // table walk (vector 0 shows zero counters after reset, R12)
        for (int vi = 0; vi < 6; vi++) begin
            if (VECS[vi].pps_first) pulse(1'b0, 1'b1);
            for (int j = 0; j < int'(VECS[vi].n_acc); j++) pulse(1'b1, 1'b0);
            set_meta(VECS[vi], vi);
            run_hdr(VECS[vi].rdy, 1'b0);
        end

        // R8: pps coinciding with new_acc leaves index at zero
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        run_hdr(8'hFF, 1'b0);
        chk(m_sec == 32'd0, "R8", m_sec, 32'd0);

        // R8: wrap from APS-1 to 0
        for (int j = 0; j < APS; j++) pulse(1'b1, 1'b0);
        run_hdr(8'b1011_0101, 1'b0);

        // R5 / R11: inputs rewritten and new_acc mid-header, extra start
        set_meta(VECS[3], 3);
        run_hdr(8'hFF, 1'b1);
        set_meta(VECS[1], 1);
        run_hdr(8'hFF, 1'b0);   // shows counters moved by the mid-header new_acc

        // R6: packet index wraps after 256 headers
        pulse(1'b1, 1'b0);
        for (int j = 0; j < 257; j++) run_hdr(8'hFF, 1'b0);
        chk(m_pkt == 8'd1, "R6", 32'(m_pkt), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule